// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Port

This block is the host side of a two-channel serial communications controller. A byte-wide bus with two address bits reaches four locations: the control port and the data port of channel A and of channel B. Each channel holds sixteen write registers and sixteen read registers. A per-channel register pointer selects the register used by the next control access, so reaching any register other than number 0 takes two control accesses. The first sets the pointer and the second moves the data.

The block decodes soft-reset commands, copies the time-constant bytes into the read side, and keeps the receive-available, transmit-empty and all-sent status bits. It takes received bytes from a line interface and hands written bytes on to the transmitter. For each channel it also presents the bit rate given by the clock, the 16-bit time constant and the clock-multiplier field. A strap input exchanges the meaning of the two address bits, so the block fits bus layouts that group registers by channel or by type.

Top module: `dsc_regport`

## Requirements
- R1: With `swap_map` low, `bus_addr[0]` selects the port (0 control, 1 data) and `bus_addr[1]` selects the channel (1 = A, 0 = B). With `swap_map` high, `bus_addr[1]` selects the port and `bus_addr[0]` selects the channel.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. If data bits 5:3 are 3'b001, the pointer also gains 8, which reaches registers 8 to 15. Register 0 itself stores nothing.
- R3: A control write to a non-zero register stores the byte and returns the pointer to 0. Every control read returns read register [pointer] on `bus_rdata` in the cycle after the strobe and then clears the pointer. `bus_rdata` holds its value when no read occurs.
- R4: A write to register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both channels. Such a write is not stored.
- R5: Writes to registers 12 and 13, the low and high bytes of the time constant, also appear in read registers 12 and 13.
- R6: After reset, register 4 holds 0x04, register 9 0xC0, register 11 0x08, register 14 0x30 and register 15 0xF8. Read register 0 holds 0x44 and read register 1 holds 0x07. Every other register holds 0.
- R7: `bit_rate` for each channel equals floor(CLK_HZ / (TC + 2)), shifted right by 0, 4, 5 or 6 when register 4 bits 7:6 are 00, 01, 10 or 11. TC is {register 13, register 12}. Channel B occupies the low RATE_W bits.
- R8: A data-port read returns the last accepted received byte and clears read register 0 bit 0 (receive available).
- R9: A data-port write sets read register 0 bit 2 (transmit empty) and read register 1 bit 0 (all sent). In the next cycle it raises the channel's `tx_load` bit for one cycle, with the byte on `tx_byte`.
- R10: A byte offered on `rx_push` is accepted only when register 3 bit 0 (receive enable) is 1 and read register 0 bit 0 is 0. Otherwise the byte is dropped and the held byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of both channels |
| swap_map | input | 1 | Strap that exchanges the port and channel address bits |
| bus_addr | input | 2 | Port and channel select |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wr | input | 1 | Write strobe, one byte per cycle (wins over bus_rd) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| rx_push | input | 2 | Received-byte offer per channel (bit 0 = B, bit 1 = A) |
| rx_byte | input | 16 | Received bytes, channel B in bits 7:0 |
| tx_load | output | 2 | One-cycle pulse per channel after a data write |
| tx_byte | output | 8 | Last byte written to a data port |
| bit_rate | output | 2*RATE_W | Effective bit rate per channel |

## Verification
Pointer sequences are driven with direct selects (0 to 7) and with the add-eight command (8 to 15). A control read that returns register 0 after each access shows whether the pointer fell back to zero. Reset commands are issued from one channel against the other, and the mirrored time constant shows which channel was cleared. The bit rate is tried at three time constants and all four multipliers, and each rate is checked against the other channel's untouched value. Receive offers are made while reception is disabled, while enabled and empty, and while a byte is already held. The same access is repeated with the strap high, which separates the two address maps.

// File: rtl/dsc_regport_pkg.sv
package dsc_regport_pkg;
    localparam int NCH    = 2;
    localparam int NREG   = 16;
    localparam int PTR_W  = $clog2(NREG);
    localparam int DW     = 8;

    localparam int WR_RXCFG = 3;
    localparam int WR_FMT   = 4;
    localparam int WR_MCTL  = 9;
    localparam int WR_CKSRC = 11;
    localparam int WR_TCLO  = 12;
    localparam int WR_TCHI  = 13;
    localparam int WR_AUX   = 14;
    localparam int WR_XEN   = 15;
    localparam int RR_STAT  = 0;
    localparam int RR_SPEC  = 1;

    typedef struct packed {
        logic [PTR_W-1:0]         ptr;
        logic [NREG-1:0][DW-1:0]  wr;
        logic [NREG-1:0][DW-1:0]  rr;
        logic [DW-1:0]            rxbuf;
    } chan_state_t;

    typedef struct packed {
        logic [DW-1:0]  rdata;
        logic [NCH-1:0] tx_load;
        logic [DW-1:0]  tx_byte;
    } port_state_t;

    function automatic chan_state_t chan_reset_value();
        chan_state_t s;
        s = '0;
        s.wr[WR_FMT]   = 8'h04;
        s.wr[WR_MCTL]  = 8'hC0;
        s.wr[WR_CKSRC] = 8'h08;
        s.wr[WR_AUX]   = 8'h30;
        s.wr[WR_XEN]   = 8'hF8;
        s.rr[RR_STAT]  = 8'h44;
        s.rr[RR_SPEC]  = 8'h07;
        return s;
    endfunction
endpackage

// File: rtl/dsc_addr_map.sv
module dsc_addr_map (
    input  logic       swap_map,
    input  logic [1:0] addr,
    output logic       is_data,
    output logic       chan
);
    always_comb begin
        if (swap_map) begin
            is_data = addr[1];
            chan    = addr[0];
        end else begin
            is_data = addr[0];
            chan    = addr[1];
        end
    end
endmodule

// File: rtl/dsc_rate.sv
module dsc_rate #(
    parameter int CLK_HZ = 3686400,
    parameter int RATE_W = 24
) (
    input  logic [15:0]       tconst,
    input  logic [1:0]        mult_sel,
    output logic [RATE_W-1:0] rate
);
    localparam logic [31:0] CLK_C = 32'(CLK_HZ);

    logic [31:0] base;
    logic [31:0] scaled;

    always_comb begin
        base = CLK_C / ({16'b0, tconst} + 32'd2);
        case (mult_sel)
            2'b00:   scaled = base;
            2'b01:   scaled = base >> 4;
            2'b10:   scaled = base >> 5;
            default: scaled = base >> 6;
        endcase
        rate = scaled[RATE_W-1:0];
    end
endmodule

// File: rtl/dsc_chan.sv
module dsc_chan
    import dsc_regport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          ctl_wr,
    input  logic          ctl_rd,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic [DW-1:0] wdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] rd_ctl,
    output logic [DW-1:0] rd_dat,
    output logic [1:0]    rst_code,
    output logic [15:0]   tconst,
    output logic [1:0]    mult_sel
);
    chan_state_t st_d, st_q;
    logic        mctl_hit;

    assign mctl_hit = ctl_wr && (st_q.ptr == PTR_W'(WR_MCTL)) && (wdata[7:6] != 2'b00);
    assign rst_code = mctl_hit ? wdata[7:6] : 2'b00;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = chan_reset_value();
        end else begin
            if (ctl_wr) begin
                if (st_q.ptr == '0) begin
                    st_d.ptr = {1'b0, wdata[2:0]};
                    if (wdata[5:3] == 3'b001) st_d.ptr[PTR_W-1] = 1'b1;
                end else begin
                    st_d.ptr = '0;
                    if (!mctl_hit) begin
                        st_d.wr[st_q.ptr] = wdata;
                        if (st_q.ptr == PTR_W'(WR_TCLO) || st_q.ptr == PTR_W'(WR_TCHI))
                            st_d.rr[st_q.ptr] = wdata;
                    end
                end
            end else if (ctl_rd) begin
                st_d.ptr = '0;
            end
            if (dat_wr) begin
                st_d.rr[RR_STAT][2] = 1'b1;
                st_d.rr[RR_SPEC][0] = 1'b1;
            end else if (dat_rd) begin
                st_d.rr[RR_STAT][0] = 1'b0;
            end
            if (rx_push && st_q.wr[WR_RXCFG][0] && !st_q.rr[RR_STAT][0]) begin
                st_d.rxbuf          = rx_byte;
                st_d.rr[RR_STAT][0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= chan_reset_value();
        else     st_q <= st_d;
    end

    assign rd_ctl   = st_q.rr[st_q.ptr];
    assign rd_dat   = st_q.rxbuf;
    assign tconst   = {st_q.wr[WR_TCHI], st_q.wr[WR_TCLO]};
    assign mult_sel = st_q.wr[WR_FMT][7:6];

    // R3: a control read alone leaves the pointer at zero
    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && !ctl_wr) |=> (st_q.ptr == '0));

    // R5: time-constant bytes are mirrored to the read side
    a_r5_tc_mirror: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !soft_rst && st_q.ptr == PTR_W'(WR_TCLO)) |=> (st_q.rr[WR_TCLO] == $past(wdata)));

    // R4: a channel reset restores the status and pointer
    a_r4_soft_reset: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (st_q.ptr == '0 && st_q.rr[RR_STAT] == 8'h44 && st_q.wr[WR_XEN] == 8'hF8));

    // R9: a data write leaves transmit-empty set
    a_r9_tx_empty: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !soft_rst) |=> st_q.rr[RR_STAT][2]);

    // R10: with reception disabled the available flag cannot rise
    a_r10_rx_gate: assert property (@(posedge clk) disable iff (rst)
        (!st_q.rr[RR_STAT][0] && !st_q.wr[WR_RXCFG][0]) |=> !st_q.rr[RR_STAT][0]);
endmodule

// File: rtl/dsc_regport.sv
module dsc_regport
    import dsc_regport_pkg::*;
#(
    parameter int CLK_HZ = 3686400,
    parameter int RATE_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  swap_map,
    input  logic [1:0]            bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [1:0]            rx_push,
    input  logic [15:0]           rx_byte,
    output logic [1:0]            tx_load,
    output logic [7:0]            tx_byte,
    output logic [2*RATE_W-1:0]   bit_rate
);
    logic                   is_data;
    logic                   sel_chan;
    logic [NCH-1:0][DW-1:0] rd_ctl;
    logic [NCH-1:0][DW-1:0] rd_dat;
    logic [NCH-1:0][1:0]    rst_code;
    logic [NCH-1:0]         soft_rst;
    logic [NCH-1:0]         dat_wr_v;
    port_state_t            ps_d, ps_q;

    dsc_addr_map u_map (
        .swap_map (swap_map),
        .addr     (bus_addr),
        .is_data  (is_data),
        .chan     (sel_chan)
    );

    // reset code bit i clears channel i (index 0 = B, index 1 = A)
    assign soft_rst = rst_code[0] | rst_code[1];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic        hit;
        logic [15:0] tc;
        logic [1:0]  ms;

        assign hit         = (sel_chan == 1'(i));
        assign dat_wr_v[i] = bus_wr && hit && is_data;

        dsc_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .soft_rst (soft_rst[i]),
            .ctl_wr   (bus_wr && hit && !is_data),
            .ctl_rd   (bus_rd && !bus_wr && hit && !is_data),
            .dat_wr   (dat_wr_v[i]),
            .dat_rd   (bus_rd && !bus_wr && hit && is_data),
            .wdata    (bus_wdata),
            .rx_push  (rx_push[i]),
            .rx_byte  (rx_byte[i*DW +: DW]),
            .rd_ctl   (rd_ctl[i]),
            .rd_dat   (rd_dat[i]),
            .rst_code (rst_code[i]),
            .tconst   (tc),
            .mult_sel (ms)
        );

        dsc_rate #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W)) u_rate (
            .tconst   (tc),
            .mult_sel (ms),
            .rate     (bit_rate[i*RATE_W +: RATE_W])
        );
    end

    always_comb begin
        ps_d         = ps_q;
        ps_d.tx_load = dat_wr_v;
        if (bus_wr && is_data) ps_d.tx_byte = bus_wdata;
        if (bus_rd && !bus_wr)
            ps_d.rdata = is_data ? rd_dat[sel_chan] : rd_ctl[sel_chan];
    end

    always_ff @(posedge clk) begin
        if (rst) ps_q <= '0;
        else     ps_q <= ps_d;
    end

    assign bus_rdata = ps_q.rdata;
    assign tx_load   = ps_q.tx_load;
    assign tx_byte   = ps_q.tx_byte;

    // R9: transmit pulses are one-hot per write
    a_r9_tx_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_load));
endmodule

// File: tb/dsc_regport_tb.sv
`timescale 1ns/1ps
module dsc_regport_tb;
    localparam int CLK_HZ = 3686400;
    localparam int RATE_W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic swap_map = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] rx_push = 2'b00;
    logic [15:0] rx_byte = 16'h0000;
    logic [1:0] tx_load;
    logic [7:0] tx_byte;
    logic [2*RATE_W-1:0] bit_rate;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsc_regport #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W)) u_dut (
        .clk(clk), .rst(rst), .swap_map(swap_map), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_load(tx_load), .tx_byte(tx_byte), .bit_rate(bit_rate)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // default map: {chan, port}; chan 1 = A, port 1 = data
    function automatic logic [1:0] adr(input bit chan_a, input bit data);
        return swap_map ? {data, chan_a} : {chan_a, data};
    endfunction

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_ptr(input bit ca, input int r);
        if (r != 0) do_wr(adr(ca, 0), (r >= 8) ? 8'(8'h08 | (r & 7)) : 8'(r));
    endtask

    task automatic rd_reg(input bit ca, input int r, output logic [7:0] d);
        set_ptr(ca, r);
        do_rd(adr(ca, 0), d);
    endtask

    task automatic wr_reg(input bit ca, input int r, input logic [7:0] v);
        set_ptr(ca, r);
        do_wr(adr(ca, 0), v);
    endtask

    function automatic logic [31:0] exp_rate(input int tc, input int m);
        int b;
        b = CLK_HZ / (tc + 2);
        case (m)
            0: return 32'(b);
            1: return 32'(b >> 4);
            2: return 32'(b >> 5);
            default: return 32'(b >> 6);
        endcase
    endfunction

    task automatic t_reset_values();
        logic [7:0] d;
        rd_reg(1, 0, d);  check("R6 A RR0", 32'(d), 32'h44);
        rd_reg(1, 1, d);  check("R6 A RR1", 32'(d), 32'h07);
        rd_reg(0, 12, d); check("R6 B RR12", 32'(d), 32'h00);
        check("R6 A rate at reset", 32'(bit_rate[2*RATE_W-1:RATE_W]), exp_rate(0, 0));
        check("R7 B rate at reset", 32'(bit_rate[RATE_W-1:0]), exp_rate(0, 0));
    endtask

    task automatic t_pointer();
        logic [7:0] d;
        wr_reg(1, 5, 8'h12);
        do_rd(adr(1, 0), d); check("R3 ptr zero after write", 32'(d), 32'h44);
        wr_reg(1, 13, 8'h9C);
        rd_reg(1, 13, d); check("R2 point-high reaches 13", 32'(d), 32'h9C);
        rd_reg(1, 1, d);
        do_rd(adr(1, 0), d); check("R3 ptr zero after read", 32'(d), 32'h44);
        @(negedge clk); @(negedge clk);
        check("R3 rdata holds", 32'(bus_rdata), 32'h44);
        wr_reg(1, 13, 8'h00);
    endtask

    task automatic t_rate();
        wr_reg(1, 12, 8'h10);
        wr_reg(1, 4, 8'h44);
        check("R7 A tc16 x16", 32'(bit_rate[2*RATE_W-1:RATE_W]), exp_rate(16, 1));
        check("R7 B untouched", 32'(bit_rate[RATE_W-1:0]), exp_rate(0, 0));
        wr_reg(1, 12, 8'h00);
        wr_reg(1, 13, 8'h01);
        wr_reg(1, 4, 8'hC4);
        check("R7 A tc256 x64", 32'(bit_rate[2*RATE_W-1:RATE_W]), exp_rate(256, 3));
        wr_reg(1, 4, 8'h84);
        check("R7 A tc256 x32", 32'(bit_rate[2*RATE_W-1:RATE_W]), exp_rate(256, 2));
        wr_reg(1, 4, 8'h04);
        check("R7 A tc256 x1", 32'(bit_rate[2*RATE_W-1:RATE_W]), exp_rate(256, 0));
    endtask

    task automatic push_b(input logic [7:0] v);
        @(negedge clk);
        rx_byte[7:0] = v; rx_push[0] = 1'b1;
        @(negedge clk);
        rx_push[0] = 1'b0;
    endtask

    task automatic t_receive();
        logic [7:0] d;
        push_b(8'h11);
        rd_reg(0, 0, d); check("R10 disabled drop", 32'(d), 32'h44);
        wr_reg(0, 3, 8'h01);
        push_b(8'h5A);
        rd_reg(0, 0, d); check("R10 accepted flag", 32'(d), 32'h45);
        push_b(8'hA5);
        do_rd(adr(0, 1), d); check("R10 held byte kept", 32'(d), 32'h5A);
        rd_reg(0, 0, d); check("R8 avail cleared", 32'(d), 32'h44);
        push_b(8'h3C);
        do_rd(adr(0, 1), d); check("R8 new byte", 32'(d), 32'h3C);
    endtask

    task automatic t_transmit();
        logic [7:0] d;
        @(negedge clk);
        bus_addr = adr(1, 1); bus_wdata = 8'h7E; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 tx_load pulse", 32'(tx_load), 32'h2);
        check("R9 tx_byte", 32'(tx_byte), 32'h7E);
        @(negedge clk);
        check("R9 tx_load single", 32'(tx_load), 32'h0);
        rd_reg(1, 0, d); check("R9 tx empty", 32'(d[2]), 32'h1);
        rd_reg(1, 1, d); check("R9 all sent", 32'(d[0]), 32'h1);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        wr_reg(1, 12, 8'h22);
        wr_reg(0, 12, 8'h33);
        wr_reg(1, 9, 8'h40);
        rd_reg(1, 12, d); check("R4 A kept on B reset", 32'(d), 32'h22);
        rd_reg(0, 12, d); check("R4 B cleared", 32'(d), 32'h00);
        rd_reg(0, 3, d);  check("R4 issuing ptr zero", 32'(d), 32'h00);
        wr_reg(0, 12, 8'h33);
        wr_reg(0, 9, 8'h80);
        rd_reg(1, 12, d); check("R4 A cleared", 32'(d), 32'h00);
        rd_reg(0, 12, d); check("R5 B mirror kept", 32'(d), 32'h33);
        wr_reg(1, 12, 8'h44);
        wr_reg(1, 9, 8'hC0);
        rd_reg(1, 12, d); check("R4 both A", 32'(d), 32'h00);
        rd_reg(0, 12, d); check("R4 both B", 32'(d), 32'h00);
    endtask

    task automatic t_swap();
        logic [7:0] d;
        swap_map = 1'b1;
        wr_reg(1, 12, 8'h5C);
        do_rd(2'b01, d); check("R1 swapped ctl A", 32'(d), 32'h44);
        swap_map = 1'b0;
        rd_reg(1, 12, d); check("R1 swap reached A", 32'(d), 32'h5C);
        rd_reg(0, 12, d); check("R1 B untouched", 32'(d), 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_values();
        t_pointer();
        t_rate();
        t_receive();
        t_transmit();
        t_soft_reset();
        t_swap();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule